// File: doc/BRIEF.md
# Presettable Synchronous BCD Decade Counter

A four-bit up-counter that steps through the decimal digits 0 to 9 in 8421 code and returns to 0 after 9. On each rising clock edge it does one of four things, chosen by fixed priority: clear, load a digit from a parallel input, count up, or hold. Counting needs two enables at once. One is a "parallel" enable. The other is a "trickle" enable, which also gates the terminal-count output.

The terminal-count output is high only when the register holds 9 and the trickle enable is high. Digits are chained into a synchronous multi-digit counter by driving each higher stage's trickle enable from the stage below's terminal count. All stages share the clock, the load strobe and the parallel enable. A parameter chooses how reset acts: it either clears the register at once without a clock, or clears it on the next rising edge. The default is the clocked form.

Top module: `bcd_decade_counter`

## Requirements
- R1: With reset and load inactive and both enables high, each rising edge advances `q` by one through 0..9, and the value after 9 (binary 1001) is 0.
- R2: With `ASYNC_RST` = 0 (the default), a low `rst_n` leaves `q` unchanged until the next rising edge. That edge sets `q` to 0 regardless of `load_n`, `din` and the enables.
- R3: With `ASYNC_RST` = 1, a low `rst_n` forces `q` to 0 without waiting for a clock edge. `q` stays 0 across edges while `rst_n` is low, even if a load is requested.
- R4: With reset inactive and `load_n` low, the next rising edge copies `din` into `q`, whatever the two enables are.
- R5: With reset and load inactive, a low on `cnt_en_p` or on `cnt_en_t` keeps `q` unchanged across a rising edge.
- R6: `tc` is 1 exactly when `q` equals 9 and `cnt_en_t` is 1. It does not depend on `cnt_en_p` or `load_n`.
- R7: `tc` is combinational from `q` and `cnt_en_t`. It follows a change of `cnt_en_t` within the same clock cycle, with no edge in between.
- R8: After an out-of-range value (10 to 15) is loaded, `tc` stays 0, including for 11, 13 and 15, where bits 0 and 3 are both set. The first counting edge sets `q` to 0.
- R9: Two instances form a two-digit counter as follows. The low digit has both enables driven by a common enable. The high digit has its parallel enable driven by that common enable and its trickle enable driven by the low digit's `tc`. This chain counts 00 through 99 on successive edges and then wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Active-low reset; timing set by `ASYNC_RST` |
| load_n | input | 1 | Active-low parallel load strobe |
| cnt_en_p | input | 1 | Parallel count enable |
| cnt_en_t | input | 1 | Trickle count enable; also gates `tc` |
| din | input | DIGIT_W | Digit loaded when `load_n` is low |
| q | output | DIGIT_W | Current digit |
| tc | output | 1 | Terminal count: digit is 9 and `cnt_en_t` is high |

## Verification
The digit register drives `q` directly, so a wrong stored value or a wrong next-state choice shows at the port one edge after the stimulus. A fault in the priority between clear, load, count and hold shows the same way, and the bench samples `q` right after that edge. A fault in the terminal-count decode shows without any clock edge, either on a change of the trickle enable or on an out-of-range load that sets bits 0 and 3. A carry fault between two chained stages shows as the wrong tens digit at the step from 09 to 10, or at the wrap from 99 to 00.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

   // Action taken on the next rising edge, listed by falling precedence
   typedef enum logic [1:0] {
      ACT_CLEAR = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_COUNT = 2'd2,
      ACT_HOLD  = 2'd3
   } ctr_act_e;

endpackage

// File: rtl/bcd_act_select.sv
module bcd_act_select
   import bcd_ctr_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b0
) (
   input  logic     rst_n,
   input  logic     load_n,
   input  logic     en_p,
   input  logic     en_t,
   output ctr_act_e act
);

   logic clear_req;

   generate
      if (ASYNC_RST) begin : g_async_clr
         // the register clears itself; no clocked clear is requested
         assign clear_req = 1'b0;
      end else begin : g_sync_clr
         assign clear_req = ~rst_n;
      end
   endgenerate

   always_comb begin
      if (clear_req)          act = ACT_CLEAR;
      else if (!load_n)       act = ACT_LOAD;
      else if (en_p && en_t)  act = ACT_COUNT;
      else                    act = ACT_HOLD;
   end

endmodule

// File: rtl/bcd_next_digit.sv
module bcd_next_digit
   import bcd_ctr_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int MODULUS = 10
) (
   input  ctr_act_e           act,
   input  logic [DIGIT_W-1:0] cur,
   input  logic [DIGIT_W-1:0] din,
   output logic [DIGIT_W-1:0] nxt
);

   localparam logic [DIGIT_W-1:0] TERM = DIGIT_W'(MODULUS - 1);
   localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

   logic [DIGIT_W-1:0] incr;

   // terminal and out-of-range values both return to zero
   assign incr = (cur >= TERM) ? '0 : cur + ONE;

   always_comb begin
      unique case (act)
         ACT_CLEAR: nxt = '0;
         ACT_LOAD:  nxt = din;
         ACT_COUNT: nxt = incr;
         default:   nxt = cur;
      endcase
   end

endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg #(
   parameter int DIGIT_W   = 4,
   parameter bit ASYNC_RST = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIGIT_W-1:0] nxt,
   output logic [DIGIT_W-1:0] cur
);

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur <= '0;
            else        cur <= nxt;
         end
      end else begin : g_sync
         // clear is folded into nxt by the action selector
         always_ff @(posedge clk) begin
            cur <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode #(
   parameter int DIGIT_W = 4,
   parameter int MODULUS = 10
) (
   input  logic [DIGIT_W-1:0] cur,
   input  logic               en_t,
   output logic               tc
);

   localparam logic [DIGIT_W-1:0] TERM = DIGIT_W'(MODULUS - 1);

   // full equality, so out-of-range codes sharing set bits never match
   assign tc = en_t && (cur == TERM);

endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
   import bcd_ctr_pkg::*;
#(
   parameter int DIGIT_W   = 4,
   parameter int MODULUS   = 10,
   parameter bit ASYNC_RST = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_n,
   input  logic               cnt_en_p,
   input  logic               cnt_en_t,
   input  logic [DIGIT_W-1:0] din,
   output logic [DIGIT_W-1:0] q,
   output logic               tc
);

   localparam logic [DIGIT_W-1:0] TERM = DIGIT_W'(MODULUS - 1);

   generate
      if (DIGIT_W < 1 || DIGIT_W > 16) begin : g_bad_width
         $error("bcd_decade_counter: DIGIT_W out of range");
      end
      if (MODULUS < 2 || MODULUS > (1 << DIGIT_W)) begin : g_bad_mod
         $error("bcd_decade_counter: MODULUS does not fit DIGIT_W");
      end
   endgenerate

   ctr_act_e           act;
   logic [DIGIT_W-1:0] nxt;

   bcd_act_select #(.ASYNC_RST(ASYNC_RST)) u_act (
      .rst_n (rst_n),
      .load_n(load_n),
      .en_p  (cnt_en_p),
      .en_t  (cnt_en_t),
      .act   (act)
   );

   bcd_next_digit #(.DIGIT_W(DIGIT_W), .MODULUS(MODULUS)) u_next (
      .act(act),
      .cur(q),
      .din(din),
      .nxt(nxt)
   );

   bcd_digit_reg #(.DIGIT_W(DIGIT_W), .ASYNC_RST(ASYNC_RST)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .nxt  (nxt),
      .cur  (q)
   );

   bcd_tc_decode #(.DIGIT_W(DIGIT_W), .MODULUS(MODULUS)) u_tc (
      .cur (q),
      .en_t(cnt_en_t),
      .tc  (tc)
   );

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en_p && cnt_en_t && q == TERM) |=> (q == '0)); // R1

   AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n) |=> (q == $past(din))); // R4

   AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q)); // R5

   AST_TC_NEEDS_TRICKLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en_t) |-> (!tc)); // R6

   AST_TC_ONLY_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (q == TERM)); // R8

   AST_COUNT_LANDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && cnt_en_p && cnt_en_t) |=> (q <= TERM)); // R8

endmodule

// File: tb/bcd_decade_counter_tb.sv
`timescale 1ns/1ps
module bcd_decade_counter_tb;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, rst_a_n, load_n, en_p, en_t;
   logic [3:0] din;
   logic [3:0] q, q_a;
   logic       tc, tc_a;

   logic       c_rst_n, c_en, c_load_n;
   logic [3:0] q_lo, q_hi;
   logic       tc_lo, tc_hi;

   int n_chk = 0;
   int n_bad = 0;

   bcd_decade_counter u_dut (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_p(en_p),
      .cnt_en_t(en_t), .din(din), .q(q), .tc(tc));

   bcd_decade_counter #(.ASYNC_RST(1'b1)) u_dut_async (
      .clk(clk), .rst_n(rst_a_n), .load_n(load_n), .cnt_en_p(en_p),
      .cnt_en_t(en_t), .din(din), .q(q_a), .tc(tc_a));

   bcd_decade_counter u_lo (
      .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .cnt_en_p(c_en),
      .cnt_en_t(c_en), .din(4'd0), .q(q_lo), .tc(tc_lo));

   bcd_decade_counter u_hi (
      .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .cnt_en_p(c_en),
      .cnt_en_t(tc_lo), .din(4'd0), .q(q_hi), .tc(tc_hi));

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; rst_a_n = 1'b0; load_n = 1'b0; din = 4'd5;
      en_p = 1'b1; en_t = 1'b1;
      tick();
      chk("R2", "sync reset beats load", int'(q), 0);
      chk("R3", "async in reset", int'(q_a), 0);
      rst_n = 1'b1; rst_a_n = 1'b1; load_n = 1'b1;
   endtask

   task automatic t_count();
      for (int i = 1; i <= 10; i++) begin
         if (i == 10) chk("R6", "tc at 9", int'(tc), 1);
         else         chk("R6", "tc below 9", int'(tc), 0);
         tick();
         chk("R1", "count step", int'(q), i % 10);
      end
   endtask

   task automatic t_load();
      en_p = 1'b1; en_t = 1'b1; load_n = 1'b0; din = 4'd7;
      tick();
      chk("R4", "load beats count", int'(q), 7);
      en_p = 1'b0; en_t = 1'b0; din = 4'd3;
      tick();
      chk("R4", "load with enables low", int'(q), 3);
      load_n = 1'b1;
   endtask

   task automatic t_hold();
      en_p = 1'b0; en_t = 1'b1;
      tick();
      chk("R5", "hold on parallel low", int'(q), 3);
      en_p = 1'b1; en_t = 1'b0;
      tick();
      chk("R5", "hold on trickle low", int'(q), 3);
      en_t = 1'b1;
      tick();
      chk("R5", "resume count", int'(q), 4);
   endtask

   task automatic t_tc();
      load_n = 1'b0; din = 4'd9;
      tick();
      load_n = 1'b1; en_p = 1'b0; en_t = 1'b1;
      #1;
      chk("R6", "tc at 9 parallel low", int'(tc), 1);
      en_t = 1'b0;
      #1;
      chk("R7", "tc drops with trickle", int'(tc), 0);
      en_t = 1'b1;
      #1;
      chk("R7", "tc rises with trickle", int'(tc), 1);
      load_n = 1'b0; din = 4'd2;
      #1;
      chk("R6", "tc ignores load strobe", int'(tc), 1);
      load_n = 1'b1;
   endtask

   task automatic t_sync_reset_timing();
      rst_n = 1'b0;
      #2;
      chk("R2", "no clear before edge", int'(q), 9);
      tick();
      chk("R2", "clear on edge", int'(q), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_async_reset();
      load_n = 1'b0; din = 4'd6;
      tick();
      load_n = 1'b1;
      chk("R4", "async part loads", int'(q_a), 6);
      rst_a_n = 1'b0;
      #1;
      chk("R3", "immediate clear", int'(q_a), 0);
      load_n = 1'b0; din = 4'd8;
      tick();
      chk("R3", "reset beats load", int'(q_a), 0);
      rst_a_n = 1'b1; load_n = 1'b1;
   endtask

   task automatic t_illegal();
      en_p = 1'b0; en_t = 1'b1;
      for (int v = 10; v <= 15; v++) begin
         load_n = 1'b0; din = 4'(v);
         tick();
         load_n = 1'b1;
         chk("R8", "illegal value held", int'(q), v);
         chk("R8", "tc low on illegal", int'(tc), 0);
         en_p = 1'b1;
         tick();
         chk("R8", "illegal counts to 0", int'(q), 0);
         en_p = 1'b0;
      end
   endtask

   task automatic t_chain();
      c_rst_n = 1'b0; c_load_n = 1'b1; c_en = 1'b0;
      tick();
      c_rst_n = 1'b1; c_en = 1'b1;
      chk("R9", "chain starts at 00", int'(q_hi) * 10 + int'(q_lo), 0);
      for (int k = 1; k <= 101; k++) begin
         tick();
         chk("R9", "chain value", int'(q_hi) * 10 + int'(q_lo), k % 100);
      end
      c_en = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; rst_a_n = 1'b0; load_n = 1'b1; en_p = 1'b0;
      en_t = 1'b0; din = '0;
      c_rst_n = 1'b0; c_en = 1'b0; c_load_n = 1'b1;
      #1;
      t_reset();
      t_count();
      t_load();
      t_hold();
      t_tc();
      t_sync_reset_timing();
      t_async_reset();
      t_illegal();
      t_chain();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule